// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the target-side command interface of a small serial NOR flash model. An SPI host clocks a one-byte opcode into it, optionally followed by a 24-bit address, a dummy byte or data bytes. The interface either streams bytes back on the serial output or hands a checked write-type command to a separate status and protection unit. It takes SPI modes 0 and 3. Input bits are taken on rising serial clock edges. Output bits are launched on falling edges, most significant bit first. The chip select, serial clock and serial input are brought into the system clock domain by a synchroniser. The serial clock must run at no more than a quarter of the system clock rate.

Read data comes from a small internal array that has a read port only. The array is filled at reset with the pattern `(7*a + 0x3C) mod 256` at index `a`, over `2**ADDR_W` bytes. Identification bytes come from constants. Status bytes come from the `status_in` input, which the status unit owns. Write-type commands include status write, program, erase, write-latch control and power-down entry or exit. Each one is reported as a single-cycle `cmd_valid` pulse, with its opcode and address, after chip select rises. Program and status-write payload bytes are presented one at a time on `wdata` as they complete. The block tracks the deep power-down state itself. Execution of any command belongs to other logic.

Top module: `sflash_cmd_if`

## Requirements
- R1: The serial input is sampled on rising SCLK and SO changes only after falling SCLK, MSB first, in both mode 0 (clock idles low) and mode 3 (clock idles high). `so_oe` drops after chip select rises.
- R2: Opcode 0x03 takes three address bytes, MSB first, then returns array bytes from that address, incrementing the address after each byte.
- R3: Opcode 0x0B takes three address bytes and one dummy byte, then returns array bytes. After address `2**ADDR_W-1` the next byte comes from address 0.
- R4: Opcode 0x9F returns 0xC2, then 0x22, then the density byte (default 0x11), and keeps cycling through these three bytes while selected.
- R5: Opcode 0x05 returns the current `status_in` byte again for every byte clocked, and is accepted while `busy` is high.
- R6: Opcodes 0x06, 0x04, 0xB9, 0xAB, 0x60 and 0xC7 give exactly one one-cycle `cmd_valid` with `cmd_code` equal to the opcode, only if chip select rises after exactly 8 bits. Any other count gives no pulse.
- R7: Erase opcodes 0x20, 0x52 and 0xD8 give `cmd_valid` with the 24-bit address on `cmd_addr`, only if chip select rises after exactly 32 bits.
- R8: Opcode 0x02 takes an address and then presents each completed data byte as a one-cycle `wdata_valid` pulse. `cmd_valid` follows chip select rising only if at least one data byte was received and no partial byte is pending.
- R9: Opcode 0x01 presents its single data byte on `wdata` and gives `cmd_valid` only if chip select rises after exactly 16 bits.
- R10: An unrecognised opcode leaves `so_oe` low and produces no pulse until the next chip-select falling edge. The following command is decoded normally.
- R11: While `busy` is high, every opcode other than 0x05 is ignored: no output enable, no `cmd_valid`.
- R12: After an accepted 0xB9, every opcode other than 0xAB is ignored, including 0x05. An accepted 0xAB restores normal decoding.
- R13: After reset, `so_oe`, `cmd_valid` and `wdata_valid` are low and the interface is not powered down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from host |
| busy | input | 1 | Program, erase or status-write cycle running |
| status_in | input | 8 | Status byte returned by opcode 0x05 |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for `so` (low means high impedance) |
| cmd_valid | output | 1 | One-cycle pulse: checked write-type command |
| cmd_code | output | 8 | Opcode of the reported command |
| cmd_addr | output | 24 | Address of the reported command |
| wdata_valid | output | 1 | One-cycle pulse: payload byte ready |
| wdata | output | 8 | Payload byte of program or status write |

## Verification
Two events can land in the same system cycle. One is the chip-select rise that ends a frame, which checks its length and may raise `cmd_valid`. The other is a decode decision, either the opcode check against the busy and power-down gates or the final payload byte. The bench provokes this by raising chip select right after the last bit, and also after one to five surplus bits, across erase, latch-control, program and status-write frames in both SPI modes. It judges each frame by counting `cmd_valid` and `wdata_valid` pulses and comparing the reported code and address against the frame it sent. A second clash arises when chip select rises during a data-out phase. The bench checks that the enable drops and that the next frame starts decoding cleanly.

// File: rtl/sfci_pkg.sv
package sfci_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDID   = 8'h9F;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_SE     = 8'h20;
    localparam logic [7:0] OP_BE_A   = 8'h52;
    localparam logic [7:0] OP_BE_B   = 8'hD8;
    localparam logic [7:0] OP_CE_A   = 8'h60;
    localparam logic [7:0] OP_CE_B   = 8'hC7;
    localparam logic [7:0] OP_PP     = 8'h02;
    localparam logic [7:0] OP_DP     = 8'hB9;
    localparam logic [7:0] OP_RDP    = 8'hAB;

    localparam logic [7:0] ID_MAKER  = 8'hC2;
    localparam logic [7:0] ID_TYPE   = 8'h22;

    // Command classes: what follows the opcode byte
    typedef enum logic [3:0] {
        CL_NONE,
        CL_RDSR,
        CL_RDID,
        CL_READ,
        CL_FREAD,
        CL_SHORT,
        CL_ERASE,
        CL_PP,
        CL_WRSR
    } cmd_cls_e;

    // Source of bytes on the serial output
    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_ID,
        SRC_STAT
    } out_src_e;

    // Receive-side frame state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_OUT,
        ST_WDATA,
        ST_END,
        ST_SKIP
    } rx_st_e;

    typedef struct packed {
        logic [7:0]  code;
        logic [23:0] addr;
    } cmd_rec_t;

    function automatic cmd_cls_e classify(input logic [7:0] op);
        cmd_cls_e c;
        case (op)
            OP_RDSR:                  c = CL_RDSR;
            OP_RDID:                  c = CL_RDID;
            OP_READ:                  c = CL_READ;
            OP_FREAD:                 c = CL_FREAD;
            OP_WREN, OP_WRDI,
            OP_DP, OP_RDP,
            OP_CE_A, OP_CE_B:         c = CL_SHORT;
            OP_SE, OP_BE_A, OP_BE_B:  c = CL_ERASE;
            OP_PP:                    c = CL_PP;
            OP_WRSR:                  c = CL_WRSR;
            default:                  c = CL_NONE;
        endcase
        return c;
    endfunction

    // Fill pattern of the read-only array
    function automatic logic [7:0] fill_byte(input int unsigned idx);
        int unsigned v;
        v = idx * 7 + 32'h3C;
        return v[7:0];
    endfunction

endpackage

// File: rtl/sfci_pin_sync.sv
module sfci_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic cs_s,
    output logic si_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_fall
);
    // bit 2 = chip select, bit 1 = serial clock, bit 0 = serial data
    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [2:0] pipe [STAGES];
    logic [2:0] prev;
    logic [2:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= IDLE_PINS;
            prev <= IDLE_PINS;
        end else begin
            pipe[0] <= {cs_n, sclk, si};
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign cur       = pipe[STAGES-1];
    assign cs_s      = cur[2];
    assign si_s      = cur[0];
    assign sclk_rise =  cur[1] & ~prev[1];
    assign sclk_fall = ~cur[1] &  prev[1];
    assign cs_rise   =  cur[2] & ~prev[2];
    assign cs_fall   = ~cur[2] &  prev[2];

endmodule

// File: rtl/sfci_rom_array.sv
module sfci_rom_array
    import sfci_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) cells[i] <= fill_byte(i);
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sfci_shift_out.sv
module sfci_shift_out
    import sfci_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] DENSITY_ID = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  out_src_e          src,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              active,
    input  logic              sclk_fall,
    input  logic [7:0]        status_in,
    input  logic [7:0]        mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              so_bit
);
    localparam logic [ADDR_W-1:0] ID_LAST = ADDR_W'(2);

    logic [ADDR_W-1:0] ptr;
    logic [2:0]        cnt;
    logic [6:0]        rest;
    out_src_e          src_q;
    logic [7:0]        cur_byte;

    always_comb begin
        case (src_q)
            SRC_MEM:  cur_byte = mem_data;
            SRC_ID: begin
                if (ptr == '0)                 cur_byte = ID_MAKER;
                else if (ptr == ADDR_W'(1))    cur_byte = ID_TYPE;
                else                           cur_byte = DENSITY_ID;
            end
            default:  cur_byte = status_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            cnt    <= '0;
            rest   <= '0;
            src_q  <= SRC_STAT;
            so_bit <= 1'b0;
        end else if (load) begin
            ptr   <= start_addr;
            cnt   <= '0;
            src_q <= src;
        end else if (active && sclk_fall) begin
            if (cnt == 3'd0) begin
                so_bit <= cur_byte[7];
                rest   <= cur_byte[6:0];
            end else begin
                so_bit <= rest[6];
                rest   <= {rest[5:0], 1'b0};
            end
            if (cnt == 3'd7) begin
                if (src_q == SRC_ID && ptr == ID_LAST) ptr <= '0;
                else                                   ptr <= ptr + 1'b1;
            end
            cnt <= cnt + 3'd1;
        end
    end

    assign mem_addr = ptr;

    // R4: the identification index never leaves its three entries
    p_id_index_r4: assert property (@(posedge clk) disable iff (rst)
        (active && src_q == SRC_ID) |-> (ptr <= ID_LAST));

endmodule

// File: rtl/sfci_cmd_decode.sv
module sfci_cmd_decode
    import sfci_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_fall,
    input  logic        cs_rise,
    input  logic        sclk_rise,
    input  logic        si_s,
    input  logic        busy,
    output logic        out_en,
    output out_src_e    out_src,
    output logic        out_load,
    output logic [23:0] out_addr,
    output logic        cmd_valid,
    output logic [7:0]  cmd_code,
    output logic [23:0] cmd_addr,
    output logic        wdata_valid,
    output logic [7:0]  wdata,
    output logic        dpd
);
    rx_st_e      st;
    cmd_cls_e    cls_q;
    logic [2:0]  bitcnt;
    logic [6:0]  sh;
    logic [7:0]  opc;
    logic [23:0] addr;
    logic [1:0]  abytes;
    logic        got_byte;
    cmd_rec_t    rec;

    logic [7:0]  byte_in;
    logic        byte_done;
    cmd_cls_e    cls_in;
    logic        gate_ok;
    logic        frame_ok;

    assign byte_in   = {sh, si_s};
    assign byte_done = sclk_rise && (bitcnt == 3'd7) && (st != ST_IDLE);
    assign cls_in    = classify(byte_in);
    assign gate_ok   = (cls_in != CL_NONE)
                     && (!dpd || byte_in == OP_RDP)
                     && (!busy || cls_in == CL_RDSR);
    assign frame_ok  = (bitcnt == 3'd0)
                     && ((st == ST_END) || (st == ST_WDATA && got_byte));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cls_q       <= CL_NONE;
            bitcnt      <= '0;
            sh          <= '0;
            opc         <= '0;
            addr        <= '0;
            abytes      <= '0;
            got_byte    <= 1'b0;
            out_src     <= SRC_STAT;
            out_load    <= 1'b0;
            cmd_valid   <= 1'b0;
            rec         <= '0;
            wdata_valid <= 1'b0;
            wdata       <= '0;
            dpd         <= 1'b0;
        end else begin
            out_load    <= 1'b0;
            cmd_valid   <= 1'b0;
            wdata_valid <= 1'b0;
            if (cs_fall) begin
                st       <= ST_OPC;
                bitcnt   <= '0;
                abytes   <= '0;
                addr     <= '0;
                got_byte <= 1'b0;
            end else if (cs_rise) begin
                if (frame_ok && st != ST_IDLE) begin
                    cmd_valid <= 1'b1;
                    rec       <= '{code: opc, addr: addr};
                    if (opc == OP_DP)  dpd <= 1'b1;
                    if (opc == OP_RDP) dpd <= 1'b0;
                end
                st <= ST_IDLE;
            end else if (sclk_rise && st != ST_IDLE) begin
                sh     <= byte_in[6:0];
                bitcnt <= bitcnt + 3'd1;
                if (byte_done) begin
                    case (st)
                        ST_OPC: begin
                            opc   <= byte_in;
                            cls_q <= cls_in;
                            if (!gate_ok) begin
                                st <= ST_SKIP;
                            end else begin
                                case (cls_in)
                                    CL_RDSR: begin
                                        st       <= ST_OUT;
                                        out_src  <= SRC_STAT;
                                        out_load <= 1'b1;
                                    end
                                    CL_RDID: begin
                                        st       <= ST_OUT;
                                        out_src  <= SRC_ID;
                                        out_load <= 1'b1;
                                    end
                                    CL_SHORT: st <= ST_END;
                                    CL_WRSR:  st <= ST_WDATA;
                                    default:  st <= ST_ADDR;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            addr   <= {addr[15:0], byte_in};
                            abytes <= abytes + 2'd1;
                            if (abytes == 2'd2) begin
                                case (cls_q)
                                    CL_READ: begin
                                        st       <= ST_OUT;
                                        out_src  <= SRC_MEM;
                                        out_load <= 1'b1;
                                    end
                                    CL_FREAD: st <= ST_DUMMY;
                                    CL_PP:    st <= ST_WDATA;
                                    default:  st <= ST_END;
                                endcase
                            end
                        end
                        ST_DUMMY: begin
                            st       <= ST_OUT;
                            out_src  <= SRC_MEM;
                            out_load <= 1'b1;
                        end
                        ST_WDATA: begin
                            wdata_valid <= 1'b1;
                            wdata       <= byte_in;
                            got_byte    <= 1'b1;
                            if (cls_q == CL_WRSR) st <= ST_END;
                        end
                        ST_END:  st <= ST_SKIP;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign out_en   = (st == ST_OUT);
    assign out_addr = addr;
    assign cmd_code = rec.code;
    assign cmd_addr = rec.addr;

    // R6: a reported command lasts one cycle
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R6: a report only ever follows a chip-select release
    p_valid_after_release_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_rise));

    // R8: payload bytes are single-cycle strobes
    p_wdata_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wdata_valid |=> !wdata_valid);

    // R10: a rejected frame stays rejected until chip select toggles
    p_skip_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP && !cs_fall) |=> (st == ST_SKIP || st == ST_IDLE));

    // R12: while powered down only the release command is reported
    p_dpd_only_release_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(dpd)) |-> (cmd_code == OP_RDP));

endmodule

// File: rtl/sflash_cmd_if.sv
module sflash_cmd_if
    import sfci_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] DENSITY_ID  = 8'h11,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        si,
    input  logic        busy,
    input  logic [7:0]  status_in,
    output logic        so,
    output logic        so_oe,
    output logic        cmd_valid,
    output logic [7:0]  cmd_code,
    output logic [23:0] cmd_addr,
    output logic        wdata_valid,
    output logic [7:0]  wdata
);
    logic              cs_s, si_s;
    logic              sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic              out_en, out_load, dpd;
    out_src_e          out_src;
    logic [23:0]       out_addr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_data;

    sfci_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .si        (si),
        .cs_s      (cs_s),
        .si_s      (si_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall)
    );

    sfci_cmd_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .sclk_rise   (sclk_rise),
        .si_s        (si_s),
        .busy        (busy),
        .out_en      (out_en),
        .out_src     (out_src),
        .out_load    (out_load),
        .out_addr    (out_addr),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .cmd_addr    (cmd_addr),
        .wdata_valid (wdata_valid),
        .wdata       (wdata),
        .dpd         (dpd)
    );

    sfci_rom_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (mem_addr),
        .rd_data (mem_data)
    );

    sfci_shift_out #(.ADDR_W(ADDR_W), .DENSITY_ID(DENSITY_ID)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (out_load),
        .src        (out_src),
        .start_addr (out_addr[ADDR_W-1:0]),
        .active     (out_en),
        .sclk_fall  (sclk_fall),
        .status_in  (status_in),
        .mem_data   (mem_data),
        .mem_addr   (mem_addr),
        .so_bit     (so)
    );

    assign so_oe = out_en;

    // R1: output drive is released once chip select goes inactive
    p_release_on_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !so_oe);

    // R13: the interface leaves reset neither driving nor powered down
    p_reset_quiet_r13: assert property (@(posedge clk)
        $past(rst) |-> (!so_oe && !cmd_valid && !dpd));

endmodule

// File: tb/sflash_cmd_if_tb_top.sv
module sflash_cmd_if_tb_top;

    localparam int H = 8;   // half SCLK period in system clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        so, so_oe, cmd_valid, wdata_valid;
    logic [7:0]  cmd_code, wdata;
    logic [23:0] cmd_addr;

    always #5 clk = ~clk;

    sflash_cmd_if dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si),
        .busy(busy), .status_in(status_in), .so(so), .so_oe(so_oe),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .wdata_valid(wdata_valid), .wdata(wdata)
    );

    int n_tests = 0, n_fail = 0;
    int cv_cnt = 0, wd_cnt = 0;
    logic [7:0]  cv_code = 8'h00;
    logic [23:0] cv_addr = 24'h0;
    logic [7:0]  wd_buf [16];

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                cv_cnt  = cv_cnt + 1;
                cv_code = cmd_code;
                cv_addr = cmd_addr;
            end
            if (wdata_valid) begin
                wd_buf[wd_cnt % 16] = wdata;
                wd_cnt = wd_cnt + 1;
            end
        end
    end

    function automatic logic [7:0] pat(input int a);
        int v;
        v = (a * 7 + 60) % 256;
        return v[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_begin(input bit m3);
        sclk = m3;
        half();
        cs_n = 1'b0;
        half();
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output bit oe);
        oe = 1'b0;
        r  = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            si   = b[i];
            half();
            r[i] = so;
            if (so_oe) oe = 1'b1;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic spi_bits(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            si   = 1'b1;
            half();
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic spi_end(input bit m3);
        if (!m3) begin
            sclk = 1'b0;
            half();
        end
        cs_n = 1'b1;
        half();
        half();
    endtask

    typedef struct packed {
        logic [7:0]  opc;
        logic [1:0]  naddr;
        logic [2:0]  extra;
        logic        m3;
        logic        expv;
        logic [23:0] addr;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{opc: 8'h06, naddr: 2'd0, extra: 3'd0, m3: 1'b0, expv: 1'b1, addr: 24'h000000},
        '{opc: 8'h04, naddr: 2'd0, extra: 3'd0, m3: 1'b1, expv: 1'b1, addr: 24'h000000},
        '{opc: 8'h06, naddr: 2'd0, extra: 3'd3, m3: 1'b0, expv: 1'b0, addr: 24'h000000},
        '{opc: 8'h60, naddr: 2'd0, extra: 3'd0, m3: 1'b1, expv: 1'b1, addr: 24'h000000},
        '{opc: 8'hC7, naddr: 2'd0, extra: 3'd5, m3: 1'b0, expv: 1'b0, addr: 24'h000000},
        '{opc: 8'hC7, naddr: 2'd0, extra: 3'd0, m3: 1'b0, expv: 1'b1, addr: 24'h000000},
        '{opc: 8'h20, naddr: 2'd3, extra: 3'd0, m3: 1'b0, expv: 1'b1, addr: 24'h123456},
        '{opc: 8'h52, naddr: 2'd2, extra: 3'd0, m3: 1'b1, expv: 1'b0, addr: 24'hABCDEF},
        '{opc: 8'hD8, naddr: 2'd3, extra: 3'd0, m3: 1'b1, expv: 1'b1, addr: 24'h00FF00},
        '{opc: 8'h52, naddr: 2'd3, extra: 3'd1, m3: 1'b0, expv: 1'b0, addr: 24'h000100}
    };

    task automatic send_addr(input logic [23:0] a, input int n);
        logic [7:0] r;
        bit oe;
        for (int k = 0; k < n; k++) spi_byte(8'(a >> (16 - 8 * k)), r, oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        bit oe;
        int base, wbase;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check(!so_oe && !cmd_valid && !wdata_valid, "R13 reset outputs", {so_oe, cmd_valid, wdata_valid}, 0);

        // R6 / R7 table of write-type frames
        foreach (VEC[i]) begin
            base = cv_cnt;
            spi_begin(VEC[i].m3);
            spi_byte(VEC[i].opc, r, oe);
            send_addr(VEC[i].addr, int'(VEC[i].naddr));
            spi_bits(int'(VEC[i].extra));
            spi_end(VEC[i].m3);
            check((cv_cnt - base) == int'(VEC[i].expv), (VEC[i].naddr != 0) ? "R7 pulse count" : "R6 pulse count",
                  cv_cnt - base, VEC[i].expv);
            if (VEC[i].expv) begin
                check(cv_code == VEC[i].opc, "R6 code", cv_code, VEC[i].opc);
                if (VEC[i].naddr == 2'd3) check(cv_addr == VEC[i].addr, "R7 address", cv_addr, VEC[i].addr);
            end
        end

        // R2 READ in mode 0 with increment
        spi_begin(1'b0);
        spi_byte(8'h03, r, oe);
        send_addr(24'h0000F0, 3);
        for (int k = 0; k < 3; k++) begin
            spi_byte(8'h00, r, oe);
            check(r == pat(8'hF0 + k) && oe, "R2 read byte", r, pat(8'hF0 + k));
        end
        spi_end(1'b0);
        check(!so_oe, "R1 output released", so_oe, 0);

        // R3 FAST_READ in mode 3 across the top of the array
        spi_begin(1'b1);
        spi_byte(8'h0B, r, oe);
        send_addr(24'h0000FE, 3);
        spi_byte(8'h00, r, oe);
        for (int k = 0; k < 4; k++) begin
            spi_byte(8'h00, r, oe);
            check(r == pat((8'hFE + k) % 256), "R3 fast read wrap", r, pat((8'hFE + k) % 256));
        end
        spi_end(1'b1);

        // R4 identification cycle
        spi_begin(1'b0);
        spi_byte(8'h9F, r, oe);
        spi_byte(8'h00, r, oe); check(r == 8'hC2, "R4 maker", r, 8'hC2);
        spi_byte(8'h00, r, oe); check(r == 8'h22, "R4 type", r, 8'h22);
        spi_byte(8'h00, r, oe); check(r == 8'h11, "R4 density", r, 8'h11);
        spi_byte(8'h00, r, oe); check(r == 8'hC2, "R4 cycle", r, 8'hC2);
        spi_end(1'b0);

        // R5 / R1 status read, repeated and live, in mode 3
        status_in = 8'h5C;
        spi_begin(1'b1);
        spi_byte(8'h05, r, oe);
        spi_byte(8'h00, r, oe); check(r == 8'h5C, "R1 mode3 status", r, 8'h5C);
        status_in = 8'hA3;
        spi_byte(8'h00, r, oe); check(r == 8'hA3, "R5 status repeat", r, 8'hA3);
        spi_end(1'b1);

        // R11 busy gating; R5 status read still works
        busy = 1'b1;
        status_in = 8'h03;
        spi_begin(1'b0);
        spi_byte(8'h03, r, oe);
        send_addr(24'h000010, 3);
        spi_byte(8'h00, r, oe);
        spi_end(1'b0);
        check(!oe, "R11 read ignored while busy", oe, 0);
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'h06, r, oe); spi_end(1'b0);
        check(cv_cnt == base, "R11 latch command ignored", cv_cnt - base, 0);
        spi_begin(1'b0); spi_byte(8'h9F, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b0);
        check(!oe, "R11 id ignored while busy", oe, 0);
        spi_begin(1'b0); spi_byte(8'h05, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b0);
        check(r == 8'h03 && oe, "R5 status while busy", r, 8'h03);
        busy = 1'b0;

        // R10 unknown opcode, then recovery
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'hFF, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b0);
        check(!oe && cv_cnt == base, "R10 unknown opcode silent", {oe, 1'b0}, 0);
        status_in = 8'h42;
        spi_begin(1'b0); spi_byte(8'h05, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b0);
        check(r == 8'h42 && oe, "R10 next frame decoded", r, 8'h42);

        // R8 page program payload
        base = cv_cnt; wbase = wd_cnt;
        spi_begin(1'b1);
        spi_byte(8'h02, r, oe);
        send_addr(24'h000010, 3);
        spi_byte(8'hA1, r, oe); spi_byte(8'hB2, r, oe); spi_byte(8'hC3, r, oe);
        spi_end(1'b1);
        check(wd_cnt - wbase == 3, "R8 payload count", wd_cnt - wbase, 3);
        check(wd_buf[wbase % 16] == 8'hA1 && wd_buf[(wbase + 2) % 16] == 8'hC3, "R8 payload bytes",
              wd_buf[(wbase + 2) % 16], 8'hC3);
        check(cv_cnt - base == 1 && cv_code == 8'h02 && cv_addr == 24'h000010, "R8 program report", cv_code, 8'h02);
        base = cv_cnt;
        spi_begin(1'b0);
        spi_byte(8'h02, r, oe);
        send_addr(24'h000020, 3);
        spi_byte(8'h77, r, oe);
        spi_bits(4);
        spi_end(1'b0);
        check(cv_cnt == base, "R8 partial byte rejects", cv_cnt - base, 0);
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'h02, r, oe); send_addr(24'h000020, 3); spi_end(1'b0);
        check(cv_cnt == base, "R8 no payload rejects", cv_cnt - base, 0);

        // R9 status write
        base = cv_cnt; wbase = wd_cnt;
        spi_begin(1'b0); spi_byte(8'h01, r, oe); spi_byte(8'h8C, r, oe); spi_end(1'b0);
        check(cv_cnt - base == 1 && cv_code == 8'h01, "R9 status write report", cv_code, 8'h01);
        check(wd_cnt - wbase == 1 && wd_buf[wbase % 16] == 8'h8C, "R9 status byte", wd_buf[wbase % 16], 8'h8C);
        base = cv_cnt;
        spi_begin(1'b1); spi_byte(8'h01, r, oe); spi_byte(8'h8C, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b1);
        check(cv_cnt == base, "R9 overlong rejects", cv_cnt - base, 0);

        // R12 deep power-down
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'hB9, r, oe); spi_end(1'b0);
        check(cv_cnt - base == 1 && cv_code == 8'hB9, "R12 enter power-down", cv_code, 8'hB9);
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'h06, r, oe); spi_end(1'b0);
        check(cv_cnt == base, "R12 latch ignored when down", cv_cnt - base, 0);
        spi_begin(1'b0); spi_byte(8'h05, r, oe); spi_byte(8'h00, r, oe); spi_end(1'b0);
        check(!oe, "R12 status ignored when down", oe, 0);
        base = cv_cnt;
        spi_begin(1'b1); spi_byte(8'hAB, r, oe); spi_end(1'b1);
        check(cv_cnt - base == 1 && cv_code == 8'hAB, "R12 release", cv_code, 8'hAB);
        base = cv_cnt;
        spi_begin(1'b0); spi_byte(8'h06, r, oe); spi_end(1'b0);
        check(cv_cnt - base == 1 && cv_code == 8'h06, "R12 decoding restored", cv_code, 8'h06);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule